// File: doc/BRIEF.md
# Layer Pixel Expander with Colour Table

This block sits in the per-layer path of a display pipeline, between the framebuffer fetch and the blender. Each cycle it receives one raw pixel word and the screen coordinate that the timing generator is currently scanning. It unpacks the word according to one of eight selectable pixel layouts into a 32-bit ARGB value with 8 bits per channel. It also reports whether that coordinate falls inside the layer's rectangular window.

Luminance-based layouts can be passed through a 256-entry RGB colour table, which software fills through an indexed write port. When the table is switched off, luminance becomes grey. Window bounds are given relative to the active area. The block adds the accumulated back porch to them so they can be compared directly against raw scan coordinates. When the layer is off, or the coordinate lies outside the window, the block emits a configurable default colour, which is normally transparent black.

The result is registered, so it appears one clock after the inputs are presented. In a two-layer system one instance feeds the bottom blend input (layer 0) and another feeds the top (layer 1).

Top module: `layer_pix_expand`

## Requirements
- R1: While reset is low at a clock edge, the following cycle shows `out_argb` = 0 and `out_inside` = 0.
- R2: `out_inside`, one cycle after the inputs, is 1 only when `win_x0 + hbp_acc + 1 <= pos_x <= win_x1 + hbp_acc` and the vertical test (R3) also passes. This flag does not depend on the layer enable.
- R3: The vertical test is `win_y0 + vbp_acc + 1 <= pos_y <= win_y1 + vbp_acc`.
- R4: Format code 0 (32-bit ARGB) passes `pix_in` through unchanged. Code 1 (24-bit RGB) takes R, G, B from bits 23:16, 15:8, 7:0 and sets alpha to 0xFF.
- R5: Code 2 (16-bit 5-6-5) takes R from bits 15:11, G from 10:5 and B from 4:0. Each channel is widened by appending its top bits, and alpha is 0xFF.
- R6: Code 3 (1-5-5-5) takes alpha from bit 15, giving 0xFF when the bit is set and 0x00 otherwise. R, G and B come from bits 14:10, 9:5 and 4:0, each widened as in R5.
- R7: Code 4 (4-4-4-4) takes A, R, G, B from bits 15:12, 11:8, 7:4 and 3:0, each nibble being doubled (0xN becomes 0xNN).
- R8: Code 5 (8-bit luminance in bits 7:0) with the table disabled gives alpha 0xFF and copies the luminance to R, G and B. Bits above 7 are ignored.
- R9: Code 5 with the table enabled gives alpha 0xFF and the table entry addressed by the luminance as RGB.
- R10: Code 6 has alpha in bits 7:4 (doubled) and luminance in bits 3:0. With the table disabled the RGB is the doubled luminance replicated to all three channels. With the table enabled it is the entry at index {4'b0, luminance}.
- R11: Code 7 has alpha in bits 15:8 and luminance in bits 7:0. The luminance is greyed or looked up exactly as for code 5.
- R12: The table enable has no effect on codes 0 to 4.
- R13: When `cfg_layer_en` is 0, or the position is outside the window, `out_argb` equals `cfg_dflt_argb`.
- R14: A table write (`lut_wr_en`, 8-bit `lut_wr_idx`, RGB in bits 23:16/15:8/7:0) is visible to pixels presented from the next cycle on. It leaves every other entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_fmt | input | 3 | Pixel layout code (see R4 to R11) |
| cfg_layer_en | input | 1 | Layer enable |
| cfg_lut_en | input | 1 | Colour table enable |
| cfg_dflt_argb | input | 32 | Colour emitted outside the window or when disabled |
| cfg_hbp_acc | input | 12 | Accumulated horizontal back porch |
| cfg_vbp_acc | input | 12 | Accumulated vertical back porch |
| cfg_win_x0 | input | 12 | Window left, active-area relative |
| cfg_win_x1 | input | 12 | Window right, active-area relative |
| cfg_win_y0 | input | 12 | Window top, active-area relative |
| cfg_win_y1 | input | 12 | Window bottom, active-area relative |
| lut_wr_en | input | 1 | Table write strobe |
| lut_wr_idx | input | 8 | Table write index |
| lut_wr_rgb | input | 24 | Table write data |
| pix_in | input | 32 | Raw pixel word, low-aligned |
| pos_x | input | 12 | Current scan column |
| pos_y | input | 12 | Current scan row |
| out_argb | output | 32 | Expanded pixel, registered |
| out_inside | output | 1 | Inside-window flag, registered |

## Verification
The bench targets the four window edges, one coordinate on each side of each edge. An off-by-one in the back-porch offset would shift one flag and substitute the default colour for a real pixel, or the reverse.

Each narrow field is driven with patterns whose top and bottom bits differ. A design that padded with zeros, or replicated the wrong bits, would return values such as 0xF8 instead of 0xFF or 0x80 instead of 0x84.

Luminance formats are driven with the table both on and off, and the 4-bit index case is included. This exposes a design that indexes with a doubled nibble, or that lets the table enable leak into direct-colour formats.

A table entry is rewritten and its neighbour re-read. This catches writes that go to the wrong address, and reads that return stale data.

// File: rtl/pix_pkg.sv
// Shared types for the layer pixel expander.
// Assumes format codes are fixed by the configuration interface.
package pix_pkg;

    typedef enum logic [2:0] {
        FMT_ARGB32 = 3'd0,
        FMT_RGB24  = 3'd1,
        FMT_R5G6B5 = 3'd2,
        FMT_A1RGB5 = 3'd3,
        FMT_ARGB4  = 3'd4,
        FMT_LUM8   = 3'd5,
        FMT_A4L4   = 3'd6,
        FMT_A8L8   = 3'd7
    } pix_fmt_e;

endpackage

// File: rtl/pix_clut.sv
// Colour table: ENTRIES words of 24-bit RGB, one synchronous write port and one
// combinational read port. Assumes the contents need no reset; software loads
// them before enabling lookup.
module pix_clut #(
    parameter int ENTRIES = 256,
    parameter int RGB_W   = 24,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [RGB_W-1:0] wr_rgb,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [RGB_W-1:0] rd_rgb
);

    logic [RGB_W-1:0] table_q [ENTRIES];

    // Store one entry per write strobe.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            table_q[wr_idx] <= wr_rgb;
        end
    end

    // Unregistered read; the caller registers the result.
    assign rd_rgb = table_q[rd_idx];

endmodule

// File: rtl/pix_unpack.sv
// Combinational unpacker: turns a low-aligned raw pixel into 8:8:8:8 ARGB.
// Narrow fields are widened by appending their top bits. Luminance layouts
// either become grey or take RGB from the colour table.
module pix_unpack
    import pix_pkg::*;
#(
    parameter int PIX_W = 32,
    parameter int IDX_W = 8
) (
    input  pix_fmt_e         fmt,
    input  logic             lut_en,
    input  logic [PIX_W-1:0] pix,
    input  logic [23:0]      lut_rgb,
    output logic [IDX_W-1:0] lut_idx,
    output logic [31:0]      argb
);

    logic [7:0] lum8;

    // Pick the luminance byte and the table index for luminance layouts.
    always_comb begin
        if (fmt == FMT_A4L4) begin
            lum8    = {pix[3:0], pix[3:0]};
            lut_idx = IDX_W'(pix[3:0]);
        end else begin
            lum8    = pix[7:0];
            lut_idx = IDX_W'(pix[7:0]);
        end
    end

    // Build the ARGB word for the selected layout.
    always_comb begin
        logic [23:0] lum_rgb;
        lum_rgb = lut_en ? lut_rgb : {lum8, lum8, lum8};
        unique case (fmt)
            FMT_ARGB32: argb = pix[31:0];
            FMT_RGB24:  argb = {8'hFF, pix[23:0]};
            FMT_R5G6B5: argb = {8'hFF,
                                pix[15:11], pix[15:13],
                                pix[10:5],  pix[10:9],
                                pix[4:0],   pix[4:2]};
            FMT_A1RGB5: argb = {{8{pix[15]}},
                                pix[14:10], pix[14:12],
                                pix[9:5],   pix[9:7],
                                pix[4:0],   pix[4:2]};
            FMT_ARGB4:  argb = {pix[15:12], pix[15:12],
                                pix[11:8],  pix[11:8],
                                pix[7:4],   pix[7:4],
                                pix[3:0],   pix[3:0]};
            FMT_LUM8:   argb = {8'hFF, lum_rgb};
            FMT_A4L4:   argb = {pix[7:4], pix[7:4], lum_rgb};
            FMT_A8L8:   argb = {pix[15:8], lum_rgb};
            default:    argb = '0;
        endcase
    end

endmodule

// File: rtl/pix_window.sv
// Window test: converts active-area window bounds to scan coordinates by
// adding the accumulated back porch, then registers whether the scan
// position lies inside. Assumes the bounds are stable while the layer is shown.
module pix_window #(
    parameter int COORD_W = 12,
    localparam int SUM_W  = COORD_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [COORD_W-1:0] hbp_acc,
    input  logic [COORD_W-1:0] vbp_acc,
    input  logic [COORD_W-1:0] win_x0,
    input  logic [COORD_W-1:0] win_x1,
    input  logic [COORD_W-1:0] win_y0,
    input  logic [COORD_W-1:0] win_y1,
    input  logic [COORD_W-1:0] pos_x,
    input  logic [COORD_W-1:0] pos_y,
    output logic               inside_q
);

    logic [SUM_W-1:0] h_start, h_stop, v_start, v_stop;
    logic             in_h, in_v;

    // Shift the window bounds into scan coordinates.
    always_comb begin
        h_start = SUM_W'(win_x0) + SUM_W'(hbp_acc) + SUM_W'(1);
        h_stop  = SUM_W'(win_x1) + SUM_W'(hbp_acc);
        v_start = SUM_W'(win_y0) + SUM_W'(vbp_acc) + SUM_W'(1);
        v_stop  = SUM_W'(win_y1) + SUM_W'(vbp_acc);
        in_h    = (SUM_W'(pos_x) >= h_start) && (SUM_W'(pos_x) <= h_stop);
        in_v    = (SUM_W'(pos_y) >= v_start) && (SUM_W'(pos_y) <= v_stop);
    end

    // Register the combined inside flag.
    always_ff @(posedge clk) begin
        if (!rst_n) inside_q <= 1'b0;
        else        inside_q <= in_h && in_v;
    end

    // A column at or left of the back porch can never be inside.
    assert_left_of_porch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_x <= hbp_acc) |=> !inside_q);

    // A row at or above the back porch can never be inside.
    assert_above_porch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_y <= vbp_acc) |=> !inside_q);

endmodule

// File: rtl/layer_pix_expand.sv
// Layer pixel expander top: unpacks one raw pixel per cycle to ARGB, applies
// the optional colour table and substitutes the default colour outside the
// window or when the layer is off. One register stage, synchronous reset.
module layer_pix_expand
    import pix_pkg::*;
#(
    parameter int COORD_W     = 12,
    parameter int PIX_W       = 32,
    parameter int LUT_ENTRIES = 256,
    localparam int IDX_W      = $clog2(LUT_ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         cfg_fmt,
    input  logic               cfg_layer_en,
    input  logic               cfg_lut_en,
    input  logic [31:0]        cfg_dflt_argb,
    input  logic [COORD_W-1:0] cfg_hbp_acc,
    input  logic [COORD_W-1:0] cfg_vbp_acc,
    input  logic [COORD_W-1:0] cfg_win_x0,
    input  logic [COORD_W-1:0] cfg_win_x1,
    input  logic [COORD_W-1:0] cfg_win_y0,
    input  logic [COORD_W-1:0] cfg_win_y1,
    input  logic               lut_wr_en,
    input  logic [IDX_W-1:0]   lut_wr_idx,
    input  logic [23:0]        lut_wr_rgb,
    input  logic [PIX_W-1:0]   pix_in,
    input  logic [COORD_W-1:0] pos_x,
    input  logic [COORD_W-1:0] pos_y,
    output logic [31:0]        out_argb,
    output logic               out_inside
);

    pix_fmt_e         fmt;
    logic [IDX_W-1:0] lut_idx;
    logic [23:0]      lut_rgb;
    logic [31:0]      argb_d;
    logic             inside_now;

    assign fmt = pix_fmt_e'(cfg_fmt);

    pix_clut #(.ENTRIES(LUT_ENTRIES), .RGB_W(24)) u_clut (
        .clk    (clk),
        .wr_en  (lut_wr_en),
        .wr_idx (lut_wr_idx),
        .wr_rgb (lut_wr_rgb),
        .rd_idx (lut_idx),
        .rd_rgb (lut_rgb)
    );

    pix_unpack #(.PIX_W(PIX_W), .IDX_W(IDX_W)) u_unpack (
        .fmt     (fmt),
        .lut_en  (cfg_lut_en),
        .pix     (pix_in),
        .lut_rgb (lut_rgb),
        .lut_idx (lut_idx),
        .argb    (argb_d)
    );

    pix_window #(.COORD_W(COORD_W)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .hbp_acc  (cfg_hbp_acc),
        .vbp_acc  (cfg_vbp_acc),
        .win_x0   (cfg_win_x0),
        .win_x1   (cfg_win_x1),
        .win_y0   (cfg_win_y0),
        .win_y1   (cfg_win_y1),
        .pos_x    (pos_x),
        .pos_y    (pos_y),
        .inside_q (inside_now)
    );

    // Same-cycle inside decision, recomputed for the colour select.
    logic inside_comb;
    always_comb begin
        inside_comb =
            ({1'b0, pos_x} >= {1'b0, cfg_win_x0} + {1'b0, cfg_hbp_acc} + 1'b1) &&
            ({1'b0, pos_x} <= {1'b0, cfg_win_x1} + {1'b0, cfg_hbp_acc}) &&
            ({1'b0, pos_y} >= {1'b0, cfg_win_y0} + {1'b0, cfg_vbp_acc} + 1'b1) &&
            ({1'b0, pos_y} <= {1'b0, cfg_win_y1} + {1'b0, cfg_vbp_acc});
    end

    // Register the visible colour, or the default one when hidden.
    always_ff @(posedge clk) begin
        if (!rst_n)                            out_argb <= '0;
        else if (cfg_layer_en && inside_comb)  out_argb <= argb_d;
        else                                   out_argb <= cfg_dflt_argb;
    end

    assign out_inside = inside_now;

    // Reset clears both outputs on the following cycle.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (out_argb == 32'h0) && !out_inside);

    // A disabled layer shows only the default colour.
    assert_disabled_default_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_layer_en |=> out_argb == $past(cfg_dflt_argb));

    // Layouts without alpha always yield opaque pixels inside the window.
    assert_opaque_noalpha_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_layer_en && (cfg_fmt == 3'd1 || cfg_fmt == 3'd2 || cfg_fmt == 3'd5))
        |=> !out_inside || out_argb[31:24] == 8'hFF);

    // One-bit alpha expands to fully transparent or fully opaque only.
    assert_onebit_alpha_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_layer_en && cfg_fmt == 3'd3)
        |=> !out_inside || out_argb[31:24] == 8'h00 || out_argb[31:24] == 8'hFF);

endmodule

// File: tb/tb_layer_pix_expand.sv
module tb_layer_pix_expand;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  cfg_fmt;
    logic        cfg_layer_en, cfg_lut_en;
    logic [31:0] cfg_dflt_argb;
    logic [11:0] cfg_hbp_acc, cfg_vbp_acc;
    logic [11:0] cfg_win_x0, cfg_win_x1, cfg_win_y0, cfg_win_y1;
    logic        lut_wr_en;
    logic [7:0]  lut_wr_idx;
    logic [23:0] lut_wr_rgb;
    logic [31:0] pix_in;
    logic [11:0] pos_x, pos_y;
    logic [31:0] out_argb;
    logic        out_inside;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    layer_pix_expand dut (
        .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_layer_en(cfg_layer_en),
        .cfg_lut_en(cfg_lut_en), .cfg_dflt_argb(cfg_dflt_argb),
        .cfg_hbp_acc(cfg_hbp_acc), .cfg_vbp_acc(cfg_vbp_acc),
        .cfg_win_x0(cfg_win_x0), .cfg_win_x1(cfg_win_x1),
        .cfg_win_y0(cfg_win_y0), .cfg_win_y1(cfg_win_y1),
        .lut_wr_en(lut_wr_en), .lut_wr_idx(lut_wr_idx), .lut_wr_rgb(lut_wr_rgb),
        .pix_in(pix_in), .pos_x(pos_x), .pos_y(pos_y),
        .out_argb(out_argb), .out_inside(out_inside)
    );

    // Table contents loaded by the bench: R = ~i, G = i, B = i ^ 0x40.
    function automatic logic [23:0] lut_of(input logic [7:0] i);
        return {~i, i, i ^ 8'h40};
    endfunction

    // Vector: {fmt[2:0], lut_en, pix[31:0], expected[31:0]}
    localparam logic [67:0] VEC [16] = '{
        {3'd0, 1'b0, 32'h12345678, 32'h12345678},
        {3'd1, 1'b0, 32'hAB123456, 32'hFF123456},
        {3'd2, 1'b0, 32'h0000F81F, 32'hFFFF00FF},
        {3'd2, 1'b0, 32'h000007E0, 32'hFF00FF00},
        {3'd2, 1'b0, 32'h00008410, 32'hFF848284},
        {3'd3, 1'b0, 32'h00007C00, 32'h00FF0000},
        {3'd3, 1'b0, 32'h00008001, 32'hFF000008},
        {3'd4, 1'b0, 32'h00001E5A, 32'h11EE55AA},
        {3'd5, 1'b0, 32'hFFFFFF3C, 32'hFF3C3C3C},
        {3'd5, 1'b1, 32'h0000003C, 32'hFFC33C7C},
        {3'd6, 1'b0, 32'h00000059, 32'h55999999},
        {3'd6, 1'b1, 32'h00000059, 32'h55F60949},
        {3'd7, 1'b0, 32'h00002781, 32'h27818181},
        {3'd7, 1'b1, 32'h00002781, 32'h277E81C1},
        {3'd0, 1'b1, 32'h12345678, 32'h12345678},
        {3'd2, 1'b1, 32'h0000F81F, 32'hFFFF00FF}
    };

    function automatic string tag_of(input logic [2:0] f, input logic l);
        if (l && f < 3'd5) return "R12";
        case (f)
            3'd0, 3'd1: return "R4";
            3'd2:       return "R5";
            3'd3:       return "R6";
            3'd4:       return "R7";
            3'd5:       return l ? "R9" : "R8";
            3'd6:       return "R10";
            default:    return "R11";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", req, act, exp);
        end
    endtask

    // Inputs change after a negedge; result sampled one negedge later.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic at_pos(input logic [11:0] x, input logic [11:0] y);
        pos_x = x;
        pos_y = y;
        step();
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        cfg_fmt = 3'd0; cfg_layer_en = 1'b1; cfg_lut_en = 1'b0;
        cfg_dflt_argb = 32'h0;
        cfg_hbp_acc = 12'd10; cfg_vbp_acc = 12'd3;
        cfg_win_x0 = 12'd0; cfg_win_x1 = 12'd100;
        cfg_win_y0 = 12'd0; cfg_win_y1 = 12'd50;
        lut_wr_en = 1'b0; lut_wr_idx = '0; lut_wr_rgb = '0;
        pix_in = 32'hDEADBEEF; pos_x = 12'd50; pos_y = 12'd20;
        @(negedge clk);
        step();
        // R1: reset state even with an inside position and enabled layer
        check("R1", out_argb, 32'h0);
        check("R1", {31'b0, out_inside}, 32'h0);
        rst_n = 1'b1;

        // Load the whole colour table.
        for (int i = 0; i < 256; i++) begin
            lut_wr_en = 1'b1; lut_wr_idx = 8'(i); lut_wr_rgb = lut_of(8'(i));
            step();
        end
        lut_wr_en = 1'b0;

        // Main table of layouts, inside the window.
        for (int k = 0; k < 16; k++) begin
            cfg_fmt    = VEC[k][67:65];
            cfg_lut_en = VEC[k][64];
            pix_in     = VEC[k][63:32];
            step();
            check(tag_of(VEC[k][67:65], VEC[k][64]), out_argb, VEC[k][31:0]);
        end

        // Window edges: x window 16..30, y window 6..9.
        cfg_fmt = 3'd0; cfg_lut_en = 1'b0; pix_in = 32'hCAFEF00D;
        cfg_win_x0 = 12'd5; cfg_win_x1 = 12'd20;
        cfg_win_y0 = 12'd2; cfg_win_y1 = 12'd6;
        cfg_dflt_argb = 32'h11223344;
        at_pos(12'd15, 12'd7);
        check("R2", {31'b0, out_inside}, 32'h0);
        check("R13", out_argb, 32'h11223344);
        at_pos(12'd16, 12'd7);
        check("R2", {31'b0, out_inside}, 32'h1);
        check("R2", out_argb, 32'hCAFEF00D);
        at_pos(12'd30, 12'd7);
        check("R2", {31'b0, out_inside}, 32'h1);
        at_pos(12'd31, 12'd7);
        check("R2", {31'b0, out_inside}, 32'h0);
        check("R13", out_argb, 32'h11223344);
        at_pos(12'd20, 12'd5);
        check("R3", {31'b0, out_inside}, 32'h0);
        at_pos(12'd20, 12'd6);
        check("R3", {31'b0, out_inside}, 32'h1);
        at_pos(12'd20, 12'd9);
        check("R3", {31'b0, out_inside}, 32'h1);
        at_pos(12'd20, 12'd10);
        check("R3", {31'b0, out_inside}, 32'h0);
        cfg_dflt_argb = 32'h0;
        check("R13", out_argb, 32'h11223344);
        at_pos(12'd20, 12'd10);
        check("R13", out_argb, 32'h0);

        // R13: layer disabled inside the window gives default; flag unaffected (R2).
        cfg_layer_en = 1'b0; cfg_dflt_argb = 32'h00ABCDEF;
        at_pos(12'd20, 12'd7);
        check("R13", out_argb, 32'h00ABCDEF);
        check("R2", {31'b0, out_inside}, 32'h1);
        cfg_layer_en = 1'b1;

        // R14: rewrite entry 0x3C, then read it and its neighbour.
        lut_wr_en = 1'b1; lut_wr_idx = 8'h3C; lut_wr_rgb = 24'h123456;
        step();
        lut_wr_en = 1'b0;
        cfg_fmt = 3'd5; cfg_lut_en = 1'b1; pix_in = 32'h3C;
        step();
        check("R14", out_argb, 32'hFF123456);
        pix_in = 32'h3D;
        step();
        check("R14", out_argb, {8'hFF, lut_of(8'h3D)});

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule